// File: doc/BRIEF.md
# Banked SRAM Access Sequencer

This block is a cycle-level access controller combined with a synthesizable storage model for a word-organised memory. The storage is divided into blocks. Each block holds rows, and each row is 64 columns wide and carries two 32-bit words. The bits of the two words alternate column by column. The controller accepts one request at a time through a ready/request handshake. It decodes the address into word, row and block selects. It then steps through a bitline precharge phase, a word-line phase and a sense-or-write phase, and after a read it presents the data with a one-cycle valid pulse.

Word lines are built in two levels. A global line is raised for the decoded row, and a block's local line is raised only where that global line meets the block select. A write drives only the columns of the selected word. The partner word's columns in the same row are read and written back unchanged. When no request arrives for a programmable number of idle cycles, the block enters a retention sleep state and asks for a low supply. The next request is stalled for one wake cycle before it can be accepted.

The defaults (32 rows, 32 blocks) keep elaboration small. Setting `ROW_AW=8` and `BLK_AW=6` gives the full 1 Mbit arrangement, with 256 rows, 64 blocks and a 15-bit address.

Top module: `sram_seq`

## Requirements
- R1: The address is decoded as follows. Bit 0 is the word select, bits [ROW_AW:1] are the row, and bits [AW-1:ROW_AW+1] are the block. Any two distinct addresses hold independent words.
- R2: Word w of a row occupies columns 2*i+w, for i = 0..31. A block's local word line is active only where its global row line and its block select are both active. At most one local line is active, and only in the word-line and sense/write phases.
- R3: A request is accepted at a rising edge where both req_i and ready_o are high. The controller then passes through the precharge, word-line and sense/write phases on the next three edges. For a read, rvalid_o is high, with rdata_o valid, for exactly the one cycle after the third edge following acceptance. A write never raises rvalid_o.
- R4: A write changes only the selected word. The interleaved partner word of the same row keeps its value.
- R5: ready_o is high only in the idle state. While an access is in flight, ready_o is low and no new request is taken.
- R6: After idle_limit_i consecutive idle cycles without a request, sleep_o rises and ready_o falls. When idle_limit_i is 0, the block never sleeps.
- R7: A request that arrives during sleep passes through exactly one wake cycle, with sleep_o low and ready_o low. ready_o rises two cycles after the request is raised.
- R8: Stored words survive a sleep and wake sequence unchanged.
- R9: After reset, ready_o=1, sleep_o=0, rvalid_o=0 and rdata_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write data |
| idle_limit_i | input | CNT_W | Idle cycles before sleep, 0 disables sleep |
| ready_o | output | 1 | Request can be accepted this cycle |
| rdata_o | output | DW | Read data |
| rvalid_o | output | 1 | One-cycle read data valid pulse |
| sleep_o | output | 1 | Retention sleep, low supply requested |

## Verification
The hardest situation to reach is a request that lands while the block sleeps. The stimulus must first sit idle for exactly idle_limit_i cycles with no request, and only then raise one. The bench reaches it deliberately. It programs a short limit, counts idle cycles to the edge where sleep_o must rise, raises a request at that point, and counts the stall cycles before ready_o. It then reads back words written before the sleep. Partner preservation is provoked by writing both words of a row, overwriting one of them, and reading both back.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PRE   = 3'd1,
    PH_WL    = 3'd2,
    PH_ACT   = 3'd3,
    PH_SLEEP = 3'd4,
    PH_WAKE  = 3'd5
  } phase_e;
endpackage

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int AW    = 11,
  parameter int DW    = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [CNT_W-1:0] idle_limit_i,
  output phase_e           phase_o,
  output logic             ready_o,
  output logic             sleep_o,
  output logic             acc_we_o,
  output logic [AW-1:0]    acc_addr_o,
  output logic [DW-1:0]    acc_wdata_o
);
  phase_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept;

  assign accept = (state_q == PH_IDLE) && req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE: begin
        if (req_i) state_d = PH_PRE;
        else if (idle_limit_i != '0 && cnt_q == idle_limit_i - CNT_W'(1))
          state_d = PH_SLEEP;
      end
      PH_PRE:   state_d = PH_WL;
      PH_WL:    state_d = PH_ACT;
      PH_ACT:   state_d = PH_IDLE;
      PH_SLEEP: if (req_i) state_d = PH_WAKE;
      PH_WAKE:  state_d = PH_IDLE;
      default:  state_d = PH_IDLE;
    endcase
  end

  // idle run length, cleared on any other cycle
  assign cnt_d = (state_q == PH_IDLE && !req_i && state_d == PH_IDLE) ? cnt_q + CNT_W'(1) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= PH_IDLE;
      cnt_q       <= '0;
      acc_we_o    <= 1'b0;
      acc_addr_o  <= '0;
      acc_wdata_o <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (accept) begin
        acc_we_o    <= we_i;
        acc_addr_o  <= addr_i;
        acc_wdata_o <= wdata_i;
      end
    end
  end

  assign phase_o = state_q;
  assign ready_o = (state_q == PH_IDLE);
  assign sleep_o = (state_q == PH_SLEEP);
endmodule

// File: rtl/sram_seq_dec.sv
module sram_seq_dec #(
  parameter int ROW_AW = 5,
  parameter int BLK_AW = 5,
  localparam int AW    = 1 + ROW_AW + BLK_AW,
  localparam int ROWS  = 1 << ROW_AW,
  localparam int BLKS  = 1 << BLK_AW
) (
  input  logic [AW-1:0]     addr_i,
  input  logic              en_i,
  output logic              word_sel_o,
  output logic [ROW_AW-1:0] row_o,
  output logic [ROWS-1:0]   gwl_o,
  output logic [BLKS-1:0]   bsel_o
);
  logic [BLK_AW-1:0] blk;

  assign word_sel_o = addr_i[0];
  assign row_o      = addr_i[ROW_AW:1];
  assign blk        = addr_i[AW-1:ROW_AW+1];

  for (genvar r = 0; r < ROWS; r++) begin : g_gwl
    assign gwl_o[r] = en_i && (row_o == ROW_AW'(r));
  end
  for (genvar b = 0; b < BLKS; b++) begin : g_bsel
    assign bsel_o[b] = en_i && (blk == BLK_AW'(b));
  end
endmodule

// File: rtl/sram_seq_bank.sv
module sram_seq_bank #(
  parameter int ROW_AW = 5,
  parameter int BLK_AW = 5,
  parameter int DW     = 32,
  localparam int ROWS  = 1 << ROW_AW,
  localparam int BLKS  = 1 << BLK_AW,
  localparam int RW    = 2 * DW
) (
  input  logic                 clk_i,
  input  logic [ROWS-1:0]      gwl_i,
  input  logic [BLKS-1:0]      bsel_i,
  input  logic [ROW_AW-1:0]    row_i,
  input  logic                 wr_i,
  input  logic                 word_sel_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [RW-1:0]        rd_row_o,
  output logic [RW-1:0]        wr_row_o,
  output logic [BLKS*ROWS-1:0] lwl_o
);
  logic [RW-1:0] blk_rd [BLKS];

  // selected columns take new data, partner columns keep the sensed value
  always_comb begin
    wr_row_o = rd_row_o;
    for (int i = 0; i < DW; i++) wr_row_o[2*i + int'(word_sel_i)] = wdata_i[i];
  end

  for (genvar b = 0; b < BLKS; b++) begin : g_blk
    logic [ROWS-1:0] lwl;
    logic            hit;
    logic [RW-1:0]   mem_q [ROWS];

    assign lwl = gwl_i & {ROWS{bsel_i[b]}};
    assign lwl_o[b*ROWS +: ROWS] = lwl;
    assign hit = |lwl;

    always_ff @(posedge clk_i) begin
      if (wr_i && hit) mem_q[row_i] <= wr_row_o;
    end
    assign blk_rd[b] = hit ? mem_q[row_i] : '0;
  end

  always_comb begin
    rd_row_o = '0;
    for (int b = 0; b < BLKS; b++) rd_row_o = rd_row_o | blk_rd[b];
  end
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int ROW_AW = 5,
  parameter int BLK_AW = 5,
  parameter int DW     = 32,
  parameter int CNT_W  = 8,
  localparam int AW    = 1 + ROW_AW + BLK_AW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [CNT_W-1:0] idle_limit_i,
  output logic             ready_o,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o,
  output logic             sleep_o
);
  localparam int ROWS = 1 << ROW_AW;
  localparam int BLKS = 1 << BLK_AW;
  localparam int RW   = 2 * DW;

  phase_e              phase;
  logic                acc_we;
  logic [AW-1:0]       acc_addr;
  logic [DW-1:0]       acc_wdata;
  logic                wl_en, commit, wr;
  logic                word_sel;
  logic [ROW_AW-1:0]   row;
  logic [ROWS-1:0]     gwl;
  logic [BLKS-1:0]     bsel;
  logic [RW-1:0]       rd_row, wr_row;
  logic [BLKS*ROWS-1:0] lwl;
  logic [DW-1:0]       rd_word;

  sram_seq_ctrl #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) i_ctrl (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .idle_limit_i,
    .phase_o(phase), .ready_o, .sleep_o,
    .acc_we_o(acc_we), .acc_addr_o(acc_addr), .acc_wdata_o(acc_wdata)
  );

  assign wl_en  = (phase == PH_WL) || (phase == PH_ACT);
  assign commit = (phase == PH_ACT);
  assign wr     = commit && acc_we;

  sram_seq_dec #(.ROW_AW(ROW_AW), .BLK_AW(BLK_AW)) i_dec (
    .addr_i(acc_addr), .en_i(wl_en), .word_sel_o(word_sel),
    .row_o(row), .gwl_o(gwl), .bsel_o(bsel)
  );

  sram_seq_bank #(.ROW_AW(ROW_AW), .BLK_AW(BLK_AW), .DW(DW)) i_bank (
    .clk_i, .gwl_i(gwl), .bsel_i(bsel), .row_i(row), .wr_i(wr),
    .word_sel_i(word_sel), .wdata_i(acc_wdata),
    .rd_row_o(rd_row), .wr_row_o(wr_row), .lwl_o(lwl)
  );

  for (genvar i = 0; i < DW; i++) begin : g_deint
    assign rd_word[i] = word_sel ? rd_row[2*i+1] : rd_row[2*i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= commit && !acc_we;
      if (commit && !acc_we) rdata_o <= rd_word;
    end
  end
endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk
  import sram_seq_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NLWL = 1024
) (
  input logic            clk_i,
  input logic            rst_ni,
  input phase_e          phase_i,
  input logic            ready_i,
  input logic            sleep_i,
  input logic            rvalid_i,
  input logic            acc_we_i,
  input logic [NLWL-1:0] lwl_i,
  input logic [2*DW-1:0] rd_row_i,
  input logic [2*DW-1:0] wr_row_i,
  input logic            wr_i,
  input logic            word_sel_i
);
  function automatic logic [DW-1:0] partner(logic [2*DW-1:0] row, logic ws);
    logic [DW-1:0] w;
    for (int i = 0; i < DW; i++) w[i] = ws ? row[2*i] : row[2*i+1];
    return w;
  endfunction

  a_r3_pre_before_wl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == PH_WL |-> $past(phase_i) == PH_PRE);
  a_r3_wl_before_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == PH_ACT |-> $past(phase_i) == PH_WL);
  a_r3_valid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_i |-> ($past(phase_i) == PH_ACT && !$past(acc_we_i)));
  a_r2_lwl_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lwl_i));
  a_r2_lwl_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lwl_i) |-> (phase_i == PH_WL || phase_i == PH_ACT));
  a_r4_partner_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> partner(wr_row_i, word_sel_i) === partner(rd_row_i, word_sel_i));
  a_r5_ready_not_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> !sleep_i);
  a_r7_wake_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == PH_WAKE |=> phase_i == PH_IDLE);
  a_r7_sleep_exit_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(phase_i) == PH_SLEEP && phase_i != PH_SLEEP) |-> phase_i == PH_WAKE);
endmodule

bind sram_seq sram_seq_chk #(.DW(DW), .NLWL(BLKS*ROWS)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .phase_i(phase), .ready_i(ready_o),
  .sleep_i(sleep_o), .rvalid_i(rvalid_o), .acc_we_i(acc_we), .lwl_i(lwl),
  .rd_row_i(rd_row), .wr_row_i(wr_row), .wr_i(wr), .word_sel_i(word_sel)
);

// File: tb/test_sram_seq.sv
module test_sram_seq;
  localparam int AW = 11;
  localparam int DW = 32;
  localparam int NV = 15;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;  // write data, or expected read data
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b1, 11'h000, 32'hA0A0_0001},
    '{1'b1, 11'h001, 32'hB1B1_0002},
    '{1'b0, 11'h000, 32'hA0A0_0001},
    '{1'b0, 11'h001, 32'hB1B1_0002},
    '{1'b1, 11'h7FF, 32'hFFFF_FFFF},
    '{1'b1, 11'h7FE, 32'h0000_0000},
    '{1'b0, 11'h7FF, 32'hFFFF_FFFF},
    '{1'b0, 11'h7FE, 32'h0000_0000},
    '{1'b1, 11'h001, 32'h5555_AAAA},
    '{1'b0, 11'h000, 32'hA0A0_0001},
    '{1'b0, 11'h001, 32'h5555_AAAA},
    '{1'b1, 11'h402, 32'h1234_5678},
    '{1'b1, 11'h002, 32'h8765_4321},
    '{1'b0, 11'h402, 32'h1234_5678},
    '{1'b0, 11'h002, 32'h8765_4321}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [7:0]    idle_limit_i = '0;
  logic          ready_o, rvalid_o, sleep_o;
  logic [DW-1:0] rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] ref_mem [1 << AW];

  always #2 clk = ~clk;

  sram_seq i_sram_seq (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .idle_limit_i,
    .ready_o, .rdata_o, .rvalid_o, .sleep_o
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called just after a negedge; returns stall count and read data
  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int waits);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d;
    waits = 0;
    while (!ready_o) begin
      @(negedge clk);
      waits++;
    end
    @(posedge clk);
    #1 req_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!rvalid_o, "R3 no rvalid while busy", {31'd0, rvalid_o}, 0);
      chk(!ready_o, "R5 ready low while busy", {31'd0, ready_o}, 0);
    end
    @(negedge clk);
    chk(rvalid_o == !we, "R3 rvalid pulse only for read", {31'd0, rvalid_o}, {31'd0, !we});
    rd = rdata_o;
    if (we) ref_mem[a] = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    int w;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(ready_o == 1'b1, "R9 ready after reset", {31'd0, ready_o}, 1);
    chk(sleep_o == 1'b0, "R9 sleep after reset", {31'd0, sleep_o}, 0);
    chk(rvalid_o == 1'b0, "R9 rvalid after reset", {31'd0, rvalid_o}, 0);
    chk(rdata_o == '0, "R9 rdata after reset", rdata_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // vector table: R1 decode, R4 partner kept
    for (int v = 0; v < NV; v++) begin
      access(VEC[v].we, VEC[v].addr, VEC[v].data, rd, w);
      chk(w == 0, "R5 no stall when idle", w, 0);
      if (!VEC[v].we) chk(rd == VEC[v].data, "R1/R4 table read", rd, VEC[v].data);
    end

    // sweep: R2 interleave partners across rows and blocks
    for (int i = 0; i < 48; i++) begin
      access(1'b1, AW'(i * 37 + 5), 32'h9E37_79B9 * (i + 1) ^ 32'(i), rd, w);
    end
    for (int i = 0; i < 48; i++) begin
      logic [AW-1:0] a;
      a = AW'(i * 37 + 5);
      access(1'b0, a, '0, rd, w);
      chk(rd == ref_mem[a], "R2 sweep readback", rd, ref_mem[a]);
    end

    // R6: limit 0 never sleeps
    repeat (300) @(negedge clk);
    chk(sleep_o == 1'b0, "R6 limit zero keeps awake", {31'd0, sleep_o}, 0);

    // R6: sleep after exactly 6 idle cycles
    idle_limit_i = 8'd6;
    access(1'b0, 11'h000, '0, rd, w);
    repeat (5) @(negedge clk);
    chk(sleep_o == 1'b0, "R6 awake before limit", {31'd0, sleep_o}, 0);
    @(negedge clk);
    chk(sleep_o == 1'b1, "R6 asleep at limit", {31'd0, sleep_o}, 1);
    chk(ready_o == 1'b0, "R5 not ready in sleep", {31'd0, ready_o}, 0);

    // R7 wake stall, R8 retention
    fork
      access(1'b0, 11'h001, '0, rd, w);
      begin
        @(negedge clk);
        chk(sleep_o == 1'b0, "R7 sleep drops in wake", {31'd0, sleep_o}, 0);
        chk(ready_o == 1'b0, "R7 not ready in wake", {31'd0, ready_o}, 0);
      end
    join
    chk(w == 2, "R7 two stall cycles", w, 2);
    chk(rd == 32'h5555_AAAA, "R8 data kept in sleep", rd, 32'h5555_AAAA);
    access(1'b0, 11'h402, '0, rd, w);
    chk(rd == 32'h1234_5678, "R8 other block kept", rd, 32'h1234_5678);

    // write right after wake keeps partner (R4)
    repeat (8) @(negedge clk);
    chk(sleep_o == 1'b1, "R6 asleep again", {31'd0, sleep_o}, 1);
    access(1'b1, 11'h7FE, 32'hCAFE_F00D, rd, w);
    chk(w == 2, "R7 stall before write", w, 2);
    access(1'b0, 11'h7FF, '0, rd, w);
    chk(rd == 32'hFFFF_FFFF, "R4 partner after write", rd, 32'hFFFF_FFFF);
    access(1'b0, 11'h7FE, '0, rd, w);
    chk(rd == 32'hCAFE_F00D, "R4 written word", rd, 32'hCAFE_F00D);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule